// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-port, clocked memory for a cache or processor bus. Address, control and write data are captured in input registers on each rising edge. A read returns its word one cycle later from an output register. After a starting address has been loaded, the block supplies four consecutive data beats. The word offset of each beat comes from an internal two-bit burst counter, so the bus master presents only one address.

A burst starts when either of two address strobes is asserted. The controller-side strobe always loads. The processor-side strobe loads only while chip enable is active. On each following cycle, the advance input either steps the counter to the next beat or repeats the current beat. A mode input selects linear or interleaved beat order. Writes are byte-lane granular, gated by a global write, a byte-write enable and per-lane selects. The chip selection is taken when a burst starts. Output enable gates the read drivers without waiting for a clock. A sleep input freezes all activity and keeps the stored contents.

Top module: `burst_sram`

## Requirements
- R1: A read access sampled on rising edge k drives its word on `rdata`, with `rdata_oe` high, after edge k+1. After a write access or an idle access, `rdata_oe` is low one cycle later.
- R2: When `strobe_ctl_n` is low, `addr` is loaded as beat 0 of a new burst, whatever `ce_n` is. When `strobe_cpu_n` is low, `addr` is loaded only if `ce_n` is low. With `ce_n` high, a low `strobe_cpu_n` is ignored and the burst carries on.
- R3: On a cycle with no loading strobe, `adv_n` low steps the burst counter n to n+1 (mod 4). `adv_n` high repeats the current beat address.
- R4: With `ileave` = 0, the two low address bits of beat n are (start + n) mod 4. The upper address bits stay those of the loaded address.
- R5: With `ileave` = 1, the two low address bits of beat n are start XOR n. The upper address bits stay fixed.
- R6: `gw_n` low writes all lanes of the beat address. Lane l holds bits [9l+8:9l] of the 36-bit word.
- R7: With `gw_n` high and `bwe_n` low, only the lanes l with `bsel_n[l]` low are written. With `bwe_n` high, or with all selects high, the access is a read and no lane changes.
- R8: The selection is sampled on a loading strobe and kept for the burst. The block is selected only when `ce_n` = 0, `cs_hi` = 1 and `cs_n` = 0. While it is deselected, it writes nothing, and `rdata_oe` goes low one cycle after the deselecting access.
- R9: `oe_n` high forces `rdata_oe` low at once, without a clock edge. Lowering it again restores the registered drive state.
- R10: While `sleep` is high, no read or write takes place, strobes and advance are ignored, the contents are kept and `rdata_oe` falls. After release, the burst resumes from its held state.
- R11: Synchronous reset leaves the block deselected with `rdata_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Power-down request, active high |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ileave | input | 1 | Beat order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
The bench builds the block with four 9-bit lanes and a 4-bit address, so the array has 16 words. With that depth, every word is filled. A four-beat read burst is started from each of the 16 start addresses in both beat orders, which covers every wrap of the low address bits inside each group of four. All 16 lane-select patterns are written to one word and read back. Around these sweeps the bench places repeat, deselect, ignored-strobe, sleep and output-enable sequences. Expected words come from an arithmetic data pattern and a requirement-level model of the burst counter.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef logic [1:0] beat_t;

  // low address bits of beat n for a given start offset and ordering
  function automatic beat_t beat_low(input beat_t start, input beat_t n,
                                     input logic ileave);
    beat_t r;
    if (ileave) r = start ^ n;
    else        r = start + n;
    return r;
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  logic                    ce_n,
  input  logic                    cs_hi,
  input  logic                    cs_n,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    adv_n,
  input  logic                    ileave,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic                    s1_valid,
  output logic [LANES-1:0]        s1_mask,
  output logic [ADDR_W-1:0]       s1_addr,
  output logic [LANES*LANE_W-1:0] s1_wdata,
  output logic [ADDR_W-1:0]       base_q,
  output beat_t                   cnt_q
);
  localparam int W    = LANES * LANE_W;
  localparam int HI_W = ADDR_W - 2;

  logic              strobe;
  logic              sel_q, sel_d;
  logic [ADDR_W-1:0] base_d;
  beat_t             cnt_d;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  mask_d;

  // controller strobe always loads; processor strobe needs chip enable
  assign strobe = !strobe_ctl_n || (!strobe_cpu_n && !ce_n);

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    if (strobe) begin
      base_d = addr;
      cnt_d  = '0;
      sel_d  = !ce_n && cs_hi && !cs_n;
    end else if (!adv_n) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  assign acc_addr = {base_d[ADDR_W-1 -: HI_W],
                     beat_low(base_d[1:0], cnt_d, ileave)};

  for (genvar l = 0; l < LANES; l++) begin : g_lane_mask
    assign mask_d[l] = !gw_n || (!bwe_n && !bsel_n[l]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      s1_valid <= 1'b0;
      s1_mask  <= '0;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else if (sleep) begin
      s1_valid <= 1'b0;
      s1_mask  <= '0;
    end else begin
      sel_q    <= sel_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      s1_valid <= sel_d;
      s1_mask  <= sel_d ? mask_d : '0;
      s1_addr  <= acc_addr;
      s1_wdata <= wdata;
    end
  end

  logic unused_w;
  assign unused_w = ^{W{1'b0}};
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_mask,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata_q
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  // lane-enabled write and registered read, one port
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_mask[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
    if (rd_en) rdata_q <= mem[addr];
  end
endmodule

// File: rtl/burst_sram_out.sv
module burst_sram_out (
  input  logic clk,
  input  logic rst,
  input  logic rd_valid,
  input  logic oe_n,
  output logic q_en,
  output logic rdata_oe
);
  always_ff @(posedge clk) begin
    if (rst) q_en <= 1'b0;
    else     q_en <= rd_valid;
  end

  assign rdata_oe = q_en && !oe_n;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  logic                    ce_n,
  input  logic                    cs_hi,
  input  logic                    cs_n,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    adv_n,
  input  logic                    ileave,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int W = LANES * LANE_W;

  logic              s1_valid;
  logic [LANES-1:0]  s1_mask;
  logic [ADDR_W-1:0] s1_addr;
  logic [W-1:0]      s1_wdata;
  logic [ADDR_W-1:0] base_q;
  beat_t             cnt_q;
  logic              s1_rd;
  logic              q_en;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rst(rst), .sleep(sleep), .ce_n(ce_n), .cs_hi(cs_hi), .cs_n(cs_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .ileave(ileave), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .addr(addr),
    .wdata(wdata), .s1_valid(s1_valid), .s1_mask(s1_mask), .s1_addr(s1_addr),
    .s1_wdata(s1_wdata), .base_q(base_q), .cnt_q(cnt_q)
  );

  assign s1_rd = s1_valid && (s1_mask == '0);

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we_mask(s1_mask), .rd_en(s1_rd), .addr(s1_addr),
    .wdata(s1_wdata), .rdata_q(rdata)
  );

  burst_sram_out u_out (
    .clk(clk), .rst(rst), .rd_valid(s1_rd), .oe_n(oe_n),
    .q_en(q_en), .rdata_oe(rdata_oe)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              ce_n,
  input logic              cs_hi,
  input logic              cs_n,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic              ileave,
  input logic              gw_n,
  input logic [ADDR_W-1:0] addr,
  input logic              s1_valid,
  input logic [LANES-1:0]  s1_mask,
  input logic [ADDR_W-1:0] s1_addr,
  input logic [ADDR_W-1:0] base_q,
  input logic [1:0]        cnt_q,
  input logic              q_en
);
  logic no_load;
  assign no_load = strobe_ctl_n && (strobe_cpu_n || ce_n);

  // R11
  reset_idle_chk: assert property (@(posedge clk) $fell(rst) |-> !q_en);

  // R10
  sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!s1_valid && s1_mask == '0));

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(base_q) && $stable(cnt_q)));

  // R1
  pipe_read_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mask == '0) |=> q_en);

  // R1
  pipe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!s1_valid || s1_mask != '0) |=> !q_en);

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strobe_ctl_n) |=> (cnt_q == 2'd0 && base_q == $past(addr)));

  // R2
  cpu_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && strobe_ctl_n && !strobe_cpu_n && ce_n) |=> $stable(base_q));

  // R3
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && no_load && adv_n) |=> $stable(cnt_q));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && no_load && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> (s1_addr[ADDR_W-1:2] == base_q[ADDR_W-1:2]));

  // R5
  ileave_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && ileave) |=> (s1_addr[1:0] == (base_q[1:0] ^ cnt_q)));

  // R6
  global_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strobe_ctl_n && !gw_n && !ce_n && cs_hi && !cs_n) |=> (&s1_mask));

  // R8
  deselect_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strobe_ctl_n && ce_n) |=> !s1_valid);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .ce_n(ce_n), .cs_hi(cs_hi), .cs_n(cs_n),
  .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
  .ileave(ileave), .gw_n(gw_n), .addr(addr), .s1_valid(s1_valid),
  .s1_mask(s1_mask), .s1_addr(s1_addr), .base_q(base_q), .cnt_q(cnt_q),
  .q_en(q_en)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 4;
  localparam int L  = 4;
  localparam int LW = 9;
  localparam int W  = L * LW;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0, ce_n = 1'b1, cs_hi = 1'b0, cs_n = 1'b1;
  logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1, ileave = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [L-1:0]  bsel_n = '1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          rdata_oe;

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .sleep(sleep), .ce_n(ce_n), .cs_hi(cs_hi), .cs_n(cs_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .ileave(ileave), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // requirement-level model
  logic [W-1:0]  mm [D];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_sel = 1'b0;
  logic          pend_chk = 1'b0, pend_en = 1'b0;
  logic [W-1:0]  pend_data = '0;
  string         pend_tag = "";

  function automatic logic [W-1:0] dat(int a, int s);
    return {4'(s), 32'(a * 32'h9E3779B1 + s * 32'h01000193)};
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic strobe;
    logic [1:0] lo;
    logic [AW-1:0] a;
    logic [L-1:0] mask;
    logic e_en;
    logic [W-1:0] e_dat;
    e_en = 1'b0;
    e_dat = '0;
    if (!sleep) begin
      strobe = !strobe_ctl_n || (!strobe_cpu_n && !ce_n);
      if (strobe) begin
        m_base = addr; m_cnt = 2'd0; m_sel = !ce_n && cs_hi && !cs_n;
      end else if (!adv_n) m_cnt = m_cnt + 2'd1;
      lo = ileave ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      a = {m_base[AW-1:2], lo};
      for (int l = 0; l < L; l++) mask[l] = !gw_n || (!bwe_n && !bsel_n[l]);
      if (m_sel && mask != '0) begin
        for (int l = 0; l < L; l++)
          if (mask[l]) mm[a][l*LW +: LW] = wdata[l*LW +: LW];
      end else if (m_sel) begin
        e_en = 1'b1; e_dat = mm[a];
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (pend_chk) begin
      check({pend_tag, " drive"}, W'(rdata_oe), W'(pend_en));
      if (pend_en) check({pend_tag, " data"}, rdata, pend_data);
    end
    pend_chk = 1'b1; pend_en = e_en; pend_data = e_dat; pend_tag = tag;
  endtask

  task automatic idle_inputs();
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    ce_n = 1'b0; cs_hi = 1'b1; cs_n = 1'b0;
  endtask

  task automatic burst_read(int start, logic mode, logic use_cpu, string tag);
    idle_inputs();
    ileave = mode; addr = AW'(start);
    if (use_cpu) strobe_cpu_n = 1'b0; else strobe_ctl_n = 1'b0;
    tick(tag);
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b0;
    for (int n = 1; n < 4; n++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 reset", W'(rdata_oe), W'(0));

    // R6 fill every word with global writes in linear bursts
    for (int g = 0; g < D / 4; g++) begin
      idle_inputs(); ileave = 1'b0; gw_n = 1'b0;
      addr = AW'(g * 4); strobe_ctl_n = 1'b0; wdata = dat(g * 4, 0);
      tick("R6 fill");
      strobe_ctl_n = 1'b1; adv_n = 1'b0;
      for (int n = 1; n < 4; n++) begin
        wdata = dat(g * 4 + n, 0);
        tick("R6 fill");
      end
    end

    // R4 / R5 exhaustive read bursts, both strobes (R2)
    for (int s = 0; s < D; s++) burst_read(s, 1'b0, s[0], "R4 linear R1 R2");
    for (int s = 0; s < D; s++) burst_read(s, 1'b1, !s[0], "R5 interleaved R1 R2");

    // R3 repeat the current beat
    idle_inputs(); ileave = 1'b0; addr = 4'd5; strobe_ctl_n = 1'b0;
    tick("R3 start");
    strobe_ctl_n = 1'b1; adv_n = 1'b1;
    tick("R3 hold"); tick("R3 hold");
    adv_n = 1'b0;
    tick("R3 step");

    // R2 processor strobe ignored without chip enable
    idle_inputs(); addr = 4'd8; strobe_ctl_n = 1'b0;
    tick("R2 start");
    strobe_ctl_n = 1'b1; strobe_cpu_n = 1'b0; ce_n = 1'b1; addr = 4'd3; adv_n = 1'b0;
    tick("R2 ignored cpu strobe");
    strobe_cpu_n = 1'b1; ce_n = 1'b0;
    tick("R2 continues");

    // R7 every lane-select pattern on one word
    for (int p = 0; p < 16; p++) begin
      idle_inputs(); addr = 4'd2; strobe_ctl_n = 1'b0;
      bwe_n = 1'b0; bsel_n = L'(p); wdata = dat(2, p + 1);
      tick("R7 byte write");
      bwe_n = 1'b1; bsel_n = '1;
      tick("R7 readback");
    end
    // R7 selects without byte-write enable: read, no change
    idle_inputs(); addr = 4'd2; strobe_ctl_n = 1'b0; bsel_n = '0; wdata = '1;
    tick("R7 bwe off");
    bsel_n = '1;
    tick("R7 readback");

    // R8 deselect through each select input
    for (int v = 0; v < 3; v++) begin
      idle_inputs(); addr = 4'd9; strobe_ctl_n = 1'b0;
      if (v == 0) cs_hi = 1'b0;
      if (v == 1) cs_n = 1'b1;
      if (v == 2) ce_n = 1'b1;
      tick("R8 deselect read");
      strobe_ctl_n = 1'b1; gw_n = 1'b0; wdata = dat(9, 7);
      tick("R8 deselect write");
      gw_n = 1'b1;
      idle_inputs(); addr = 4'd9; strobe_ctl_n = 1'b0;
      tick("R8 reselect");
      strobe_ctl_n = 1'b1;
      tick("R8 readback");
    end

    // R10 sleep blocks access and holds state
    idle_inputs(); addr = 4'd7; strobe_ctl_n = 1'b0;
    tick("R10 start");
    strobe_ctl_n = 1'b1;
    sleep = 1'b1; gw_n = 1'b0; wdata = dat(7, 9);
    tick("R10 sleep write");
    strobe_ctl_n = 1'b0; addr = 4'd12; gw_n = 1'b1; adv_n = 1'b0;
    tick("R10 sleep strobe");
    tick("R10 sleep");
    sleep = 1'b0; strobe_ctl_n = 1'b1; adv_n = 1'b0;
    tick("R10 resume");
    idle_inputs(); addr = 4'd7; strobe_ctl_n = 1'b0;
    tick("R10 kept");
    strobe_ctl_n = 1'b1;
    tick("R10 kept");

    // R9 asynchronous output enable
    idle_inputs(); addr = 4'd1; strobe_ctl_n = 1'b0;
    tick("R9 setup");
    strobe_ctl_n = 1'b1;
    tick("R9 setup");
    oe_n = 1'b1; #1;
    check("R9 oe off", W'(rdata_oe), W'(0));
    oe_n = 1'b0; #1;
    check("R9 oe on", W'(rdata_oe), W'(1));

    idle_inputs();
    tick("R1 drain");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule